// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Controller

This block groups a set of interrupt sources into slots linked in a fixed priority chain. All slots share one request line to the processor and one vector bus. Each slot keeps a pending flag that a source pulse sets, and a vector byte that software can program. When the processor raises its acknowledge, the acknowledge enters the chain at slot 0 and moves down it. A slot with no eligible request lets it pass. The first slot that is eligible keeps it and places its vector on the bus, and the slots below that one never see it.

When the acknowledge is first seen, the slot that keeps it clears its pending flag and its priority level is marked as in service. The processor signals end of interrupt to release the highest in-service level. A slot at or below the highest level now in service cannot raise a request. Only a source of strictly higher priority can therefore interrupt a handler that is running. If no slot claims an acknowledge, the bus returns an all-ones spurious vector.

Top module: `irq_chain_ctrl`

## Requirements
- R1: After reset, no slot is pending, `svc_level` is zero, `cpu_irq` is low, `vec_bus` is zero, and the vector of slot i is `VEC_BASE + i`.
- R2: A high `int_req_src[i]` at a clock edge sets the pending flag of slot i. The flag stays set until the slot is acknowledged. `cpu_irq` is high exactly while some pending slot is not masked.
- R3: Slot 0 has the highest priority. On an acknowledge, the lowest-index eligible slot wins and no other slot does.
- R4: The edge that first samples `cpu_ack` high captures the winner. From the next cycle, and for as long as `cpu_ack` stays high, `vec_bus` holds the winner's vector unchanged. `vec_bus` is zero while `cpu_ack` is low.
- R5: The winning slot's pending flag clears at the capture edge.
- R6: If the winning slot's source requests at the capture edge itself, its pending flag stays set.
- R7: At the capture edge, the bit in `svc_level` for the winning slot's index is set.
- R8: If the lowest-index set bit of `svc_level` is k, then slots k and above can neither raise `cpu_irq` nor win an acknowledge. Their pending flags are kept.
- R9: A high `end_of_irq` at a clock edge clears only the lowest-index set bit of `svc_level`. With no bit set, it has no effect.
- R10: If no slot is eligible at the capture edge, `vec_bus` carries 8'hFF and `svc_level` does not change.
- R11: A high `cfg_we` at a clock edge writes `cfg_vec` into the vector of slot `cfg_sel`. Later acknowledges of that slot return the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| int_req_src | input | N_SLOTS | Per-slot request pulses, bit 0 highest priority |
| cpu_ack | input | 1 | Processor acknowledge, entering the chain at slot 0 |
| end_of_irq | input | 1 | Releases the highest-priority in-service level |
| cfg_we | input | 1 | Vector write enable |
| cfg_sel | input | $clog2(N_SLOTS) | Slot selected for the vector write |
| cfg_vec | input | 8 | Vector byte to write |
| cpu_irq | output | 1 | Shared interrupt request to the processor |
| vec_bus | output | 8 | Vector returned during acknowledge |
| svc_level | output | N_SLOTS | In-service priority levels |

## Verification
The main sequence uses single requests, pairs of requests that are far apart in the chain, and requests that arrive below a level already in service. Each ack then shows whether the chain chose the top slot of a pair, whether the mask blocked a slot while keeping its pending flag, and whether a release brought the slot back into play. Acknowledges with no eligible slot separate the spurious case from a real claim. A request that lands on the capture edge itself shows whether that request is lost or kept. A reprogrammed vector shows whether the bus is fed from the slot's register and not from a fixed value.

// File: rtl/irq_chain_pkg.sv
// Shared types for the interrupt chain: the vector byte and the spurious code.
package irq_chain_pkg;
    localparam int VEC_W = 8;
    typedef logic [VEC_W-1:0] vec_t;
    localparam vec_t SPURIOUS_VEC = '1;
endpackage

// File: rtl/irq_slot.sv
// One link of the acknowledge chain. It holds a pending flag and a vector byte.
// An acknowledge passes through when the slot is not eligible and is kept when it is.
// Assumes take_i is a one-cycle strobe at the first edge of an acknowledge.
module irq_slot
    import irq_chain_pkg::*;
#(
    parameter vec_t RESET_VEC = 8'h00
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic allow_i,
    input  logic ack_i,
    input  logic take_i,
    input  logic cfg_we_i,
    input  vec_t cfg_vec_i,
    output logic ack_o,
    output logic grant_o,
    output logic elig_o,
    output vec_t vec_o
);
    logic pend_q;
    vec_t vec_q;

    // Eligibility and the chain pass-through.
    always_comb begin
        elig_o  = pend_q & allow_i;
        grant_o = ack_i & elig_o;
        ack_o   = ack_i & ~elig_o;
        vec_o   = vec_q;
    end

    // Pending flag: a request sets it, a claim clears it, and a request wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= req_i | (pend_q & ~(grant_o & take_i));
    end

    // Programmable vector register.
    always_ff @(posedge clk) begin
        if (!rst_n)        vec_q <= RESET_VEC;
        else if (cfg_we_i) vec_q <= cfg_vec_i;
    end

    p_hold_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !(grant_o && take_i)) |=> pend_q);
    p_clear_on_claim_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && take_i && !req_i) |=> !pend_q);
    p_same_cycle_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && take_i && req_i) |=> pend_q);
endmodule

// File: rtl/irq_nest.sv
// In-service tracker. A claim sets the winner's level and end-of-interrupt
// releases the highest-priority set level (the lowest index). A slot is allowed
// only if no level at or above its own priority is in service.
module irq_nest #(
    parameter int N_SLOTS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_i,
    input  logic [N_SLOTS-1:0] grant_i,
    input  logic               end_i,
    output logic [N_SLOTS-1:0] allow_o,
    output logic [N_SLOTS-1:0] isr_o
);
    logic [N_SLOTS-1:0] isr_q;
    logic [N_SLOTS-1:0] blocked;
    logic [N_SLOTS-1:0] released;

    // Prefix OR: slot i is blocked if any level 0..i is in service.
    assign blocked[0] = isr_q[0];
    for (genvar i = 1; i < N_SLOTS; i++) begin : g_prefix
        assign blocked[i] = blocked[i-1] | isr_q[i];
    end

    // Mask out, release of the lowest set bit, and outputs.
    always_comb begin
        allow_o  = ~blocked;
        released = isr_q & (isr_q - 1'b1);
        isr_o    = isr_q;
    end

    // In-service register update: release first, then add the new claim.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (end_i ? released : isr_q) | (take_i ? grant_i : '0);
    end

    p_isr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && grant_i != '0) |=> ((isr_q & $past(grant_i)) != '0));
    p_eoi_one_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (end_i && !take_i && isr_q != '0) |=>
        ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

// File: rtl/irq_chain_ctrl.sv
// Daisy-chain interrupt controller top. It links N_SLOTS slots in priority
// order, finds the first edge of an acknowledge, latches the winner's vector
// (or the spurious code) and holds it on the bus while the acknowledge stays high.
// Assumes the processor holds cpu_ack for at least two cycles to read the vector.
module irq_chain_ctrl
    import irq_chain_pkg::*;
#(
    parameter int   N_SLOTS  = 8,
    parameter vec_t VEC_BASE = 8'h20,
    localparam int  SEL_W    = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SLOTS-1:0] int_req_src,
    input  logic               cpu_ack,
    input  logic               end_of_irq,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [VEC_W-1:0]   cfg_vec,
    output logic               cpu_irq,
    output logic [VEC_W-1:0]   vec_bus,
    output logic [N_SLOTS-1:0] svc_level
);
    logic               ack_q;
    logic               take;
    logic [N_SLOTS:0]   ack_chain;
    logic [N_SLOTS-1:0] grant;
    logic [N_SLOTS-1:0] elig;
    logic [N_SLOTS-1:0] allow;
    vec_t               slot_vec [N_SLOTS];
    vec_t               winner_vec;
    vec_t               vec_hold;

    assign ack_chain[0] = cpu_ack;
    assign take         = cpu_ack & ~ack_q;

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        irq_slot #(.RESET_VEC(vec_t'(VEC_BASE + i))) i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_i     (int_req_src[i]),
            .allow_i   (allow[i]),
            .ack_i     (ack_chain[i]),
            .take_i    (take),
            .cfg_we_i  (cfg_we && (cfg_sel == SEL_W'(i))),
            .cfg_vec_i (cfg_vec),
            .ack_o     (ack_chain[i+1]),
            .grant_o   (grant[i]),
            .elig_o    (elig[i]),
            .vec_o     (slot_vec[i])
        );
    end

    irq_nest #(.N_SLOTS(N_SLOTS)) i_nest (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (take),
        .grant_i (grant),
        .end_i   (end_of_irq),
        .allow_o (allow),
        .isr_o   (svc_level)
    );

    // Select the vector of the single granted slot, or the spurious code if none.
    always_comb begin
        winner_vec = SPURIOUS_VEC;
        for (int i = 0; i < N_SLOTS; i++)
            if (grant[i]) winner_vec = slot_vec[i];
    end

    // Acknowledge edge detector and the vector latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q    <= 1'b0;
            vec_hold <= '0;
        end else begin
            ack_q <= cpu_ack;
            if (take) vec_hold <= winner_vec;
        end
    end

    // Request line and the bus drive.
    always_comb begin
        cpu_irq = |elig;
        vec_bus = (cpu_ack && ack_q) ? vec_hold : '0;
    end

    p_one_winner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_vec_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && ack_q && $past(cpu_ack && ack_q)) |-> $stable(vec_bus));
    p_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && grant == '0) |=> (vec_hold == SPURIOUS_VEC && $stable(svc_level)));
endmodule

// File: tb/test_irq_chain_ctrl.sv
module test_irq_chain_ctrl;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] int_req_src = '0;
    logic         cpu_ack = 1'b0;
    logic         end_of_irq = 1'b0;
    logic         cfg_we = 1'b0;
    logic [2:0]   cfg_sel = '0;
    logic [7:0]   cfg_vec = '0;
    logic         cpu_irq;
    logic [7:0]   vec_bus;
    logic [N-1:0] svc_level;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    irq_chain_ctrl #(.N_SLOTS(N), .VEC_BASE(8'h20)) i_irq_chain_ctrl (
        .clk(clk), .rst_n(rst_n), .int_req_src(int_req_src), .cpu_ack(cpu_ack),
        .end_of_irq(end_of_irq), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_vec(cfg_vec),
        .cpu_irq(cpu_irq), .vec_bus(vec_bus), .svc_level(svc_level)
    );

    // Fields: eoi_first | request mask | expected irq | expected vector | expected in-service.
    localparam logic [25:0] STIM [11] = '{
        {1'b0, 8'h10, 1'b1, 8'h24, 8'h10},
        {1'b0, 8'h20, 1'b0, 8'hFF, 8'h10},
        {1'b0, 8'h04, 1'b1, 8'h22, 8'h14},
        {1'b1, 8'h00, 1'b0, 8'hFF, 8'h10},
        {1'b1, 8'h00, 1'b1, 8'h25, 8'h20},
        {1'b0, 8'h81, 1'b1, 8'h20, 8'h21},
        {1'b1, 8'h00, 1'b0, 8'hFF, 8'h20},
        {1'b1, 8'h00, 1'b1, 8'h27, 8'h80},
        {1'b1, 8'h42, 1'b1, 8'h21, 8'h02},
        {1'b1, 8'h00, 1'b1, 8'h26, 8'h40},
        {1'b1, 8'h00, 1'b0, 8'hFF, 8'h00}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_req(input logic [N-1:0] m);
        @(negedge clk) int_req_src = m;
        @(negedge clk) int_req_src = '0;
    endtask

    task automatic pulse_eoi();
        @(negedge clk) end_of_irq = 1'b1;
        @(negedge clk) end_of_irq = 1'b0;
    endtask

    // Raise the acknowledge, read the vector twice, drop it, confirm the bus is quiet.
    task automatic do_ack(input string tag, input logic [7:0] exp);
        @(negedge clk) cpu_ack = 1'b1;
        @(negedge clk) check({tag, " R4 vector"}, vec_bus, exp);
        @(negedge clk) check({tag, " R4 held"}, vec_bus, exp);
        cpu_ack = 1'b0;
        @(negedge clk) check({tag, " R4 idle bus"}, vec_bus, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", cpu_irq, 0);
        check("R1 bus", vec_bus, 0);
        check("R1 svc", svc_level, 0);

        // Table walk: R2 R3 R5 R7 R8 R9 R10
        for (int k = 0; k < 11; k++) begin
            if (STIM[k][25]) pulse_eoi();
            if (STIM[k][24:17] != '0) pulse_req(STIM[k][24:17]);
            @(negedge clk);
            check($sformatf("R2 R8 step%0d irq", k), cpu_irq, STIM[k][16]);
            do_ack($sformatf("R3 R10 step%0d", k), STIM[k][15:8]);
            check($sformatf("R7 R9 step%0d svc", k), svc_level, STIM[k][7:0]);
        end

        // R9: end of interrupt with nothing in service has no effect
        pulse_eoi();
        check("R9 empty eoi", svc_level, 0);
        check("R5 nothing left pending", cpu_irq, 0);

        // R11: reprogram slot 3 and acknowledge it
        @(negedge clk) begin cfg_we = 1'b1; cfg_sel = 3'd3; cfg_vec = 8'h5A; end
        @(negedge clk) cfg_we = 1'b0;
        pulse_req(8'h08);
        do_ack("R11 new vector", 8'h5A);
        pulse_eoi();
        check("R11 svc released", svc_level, 0);

        // R6: a request on the capture edge keeps slot 2 pending
        pulse_req(8'h04);
        @(negedge clk) begin cpu_ack = 1'b1; int_req_src = 8'h04; end
        @(negedge clk) begin int_req_src = '0; check("R6 vector", vec_bus, 8'h22); end
        cpu_ack = 1'b0;
        @(negedge clk);
        check("R6 R8 masked", cpu_irq, 0);
        pulse_eoi();
        check("R6 pending kept", cpu_irq, 1);
        do_ack("R6 second claim", 8'h22);
        pulse_eoi();
        check("R5 R6 cleared", cpu_irq, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule